// File: doc/BRIEF.md
# Cascaded Millisecond Reaction Timer

This block holds two 16-bit down-counters behind a byte-wide register bus. The first counter runs from the system clock and reloads from its latch on each pass through zero. The second counter can be set to step once per underflow of the first. With the first counter's latch set to 0x03FC and a system clock near 1.022 MHz, the first counter wraps about once per millisecond. The second counter, preset to 0xFFFF, then holds a running count of elapsed milliseconds.

An external active-low response line is synchronised into the clock domain, and its falling edge raises an interrupt flag. The flag drives an active-low interrupt output when the matching mask bit is enabled. Software answers the interrupt by stopping the first counter, reading the second counter's bytes and reading the interrupt register. That read returns the pending flags and clears them. The mask register is written with a set/clear protocol, so one source can be enabled or disabled without touching the others.

Top module: `rt_cascade_timer`

## Requirements
- R1: After reset, both counters and both latches read 0xFFFF, the mask and the flags are zero, irq_n is 1 and rd_data is 0x00.
- R2: The register map is: address 0 is the low byte of counter A, address 1 its high byte, address 2 the low byte of counter B, address 3 its high byte. A read returns the live counter byte on rd_data one cycle after the rd_en cycle. A write goes to the latch only.
- R3: A write to a high-byte address while that counter is stopped copies the complete latch, including the new byte, into the counter. While the counter runs, the same write changes only the latch.
- R4: Control A is at address 5. While its bit 0 is 1, counter A decrements once per clock. While bit 0 is 0, counter A holds its value.
- R5: When a running counter A is at zero, the next count reloads it from the latch, so one period lasts latch+1 clocks. Each such underflow sets interrupt flag bit 0.
- R6: Control B is at address 6, and its bit 0 runs counter B. With bit 6 set to 1, counter B decrements once per counter A underflow. With bit 6 at 0, it decrements once per clock. A counter B underflow reloads counter B from its latch and sets flag bit 1.
- R7: With counter A's latch at 0x03FC and counter B started at 0xFFFF in cascade mode, every 1021 clocks of counter A running lower counter B by one. The elapsed periods therefore equal 0xFFFF minus counter B.
- R8: flag_n passes through two synchroniser flip-flops. Each high-to-low transition sets flag bit 4 exactly once. Holding the line low and the rising transition set nothing.
- R9: A write to address 4 with data bit 7 at 1 sets every mask bit whose data bit is 1. With data bit 7 at 0, the same write clears every mask bit whose data bit is 1. All other mask bits keep their values.
- R10: A read of address 4 returns the flags in bits 4:0, and bit 7 at 1 when any enabled flag is pending. The read then clears the flags.
- R11: irq_n is 0 exactly when some flag is set with its mask bit enabled. irq_n follows a flag or mask change in the same clock edge that changes the flag or mask.
- R12: An event that arrives in the same clock edge as a clearing read of address 4 stays pending. That read does not report it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the count clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| flag_n | input | 1 | Asynchronous active-low response line |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The critical collision is a falling edge on the response line whose synchronised flag event lands in the same clock edge as a clearing read of the interrupt register. The bench times the line's fall so that the event reaches the flag register at exactly that read edge. It then requires that the read returns no pending flag, that irq_n still goes low, and that a second read reports the flag. A second overlap, a high-byte write to a running counter, is judged by stopping the counter afterwards and comparing its value with a pure decrement count.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Register addresses; bus address width is fixed by this map
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_A_LO = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_A_HI = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_B_LO = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_B_HI = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_ICR  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CTLA = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CTLB = 4'd6;

  // Control bit positions
  localparam int RUN_BIT  = 0;
  localparam int CASC_BIT = 6;

  // Interrupt sources
  localparam int NSRC     = 5;
  localparam int SRC_A    = 0;
  localparam int SRC_B    = 1;
  localparam int SRC_FLAG = 4;
endpackage

// File: rtl/rt_flag_edge.sv
module rt_flag_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= pin_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[STAGES-1];
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  // R8: one transition gives a single-cycle event
  p_fall_single_r8: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/rt_down_counter.sv
module rt_down_counter #(
  parameter int BYTE_W = 8,
  parameter int W      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [W-1:0]      cnt,
  output logic              uf
);
  localparam int HI_W = W - BYTE_W;

  logic [W-1:0] latch_q;
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf      = tick & at_zero;
  assign cnt     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
    end else begin
      if (wr_lo) latch_q[BYTE_W-1:0] <= wr_byte;
      if (wr_hi) latch_q[W-1:BYTE_W] <= wr_byte[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (tick) begin
      cnt_q <= at_zero ? latch_q : cnt_q - 1'b1;
    end else if (wr_hi && !run) begin
      cnt_q <= {wr_byte[HI_W-1:0], latch_q[BYTE_W-1:0]};
    end
  end

  // R5: a count at zero reloads from the latch
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && at_zero) |=> cnt_q == $past(latch_q));

  // R4: no count and no load leaves the value unchanged
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_hi && !run)) |=> $stable(cnt_q));
endmodule

// File: rtl/rt_irq_ctl.sv
module rt_irq_ctl #(
  parameter int NSRC  = 5,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  events,
  input  logic             mask_wr,
  input  logic [BUS_W-1:0] mask_data,
  input  logic             rd_clr,
  output logic [NSRC-1:0]  flags,
  output logic [NSRC-1:0]  mask,
  output logic             irq_n
);
  localparam int SETCLR = BUS_W - 1;

  logic [NSRC-1:0] flags_q, flags_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic            irq_n_q;

  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | events;
    mask_d  = mask_q;
    if (mask_wr) begin
      if (mask_data[SETCLR]) mask_d = mask_q | mask_data[NSRC-1:0];
      else                   mask_d = mask_q & ~mask_data[NSRC-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_n_q <= ~|(flags_d & mask_d);
    end
  end

  assign flags = flags_q;
  assign mask  = mask_q;
  assign irq_n = irq_n_q;

  // R12: an event is never lost, even under a clearing read
  p_event_kept_r12: assert property (@(posedge clk) disable iff (rst)
    (events != '0) |=> ((flags_q & $past(events)) == $past(events)));

  // R10: a read with no new event leaves no flag
  p_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && events == '0) |=> flags_q == '0);

  // R9: set form turns on the selected mask bits
  p_mask_set_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_data[SETCLR]) |=>
      ((mask_q & $past(mask_data[NSRC-1:0])) == $past(mask_data[NSRC-1:0])));

  // R9: clear form turns them off
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && !mask_data[SETCLR]) |=>
      ((mask_q & $past(mask_data[NSRC-1:0])) == '0));
endmodule

// File: rtl/rt_cascade_timer.sv
module rt_cascade_timer
  import rt_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              flag_n,
  output logic              irq_n
);
  localparam int CNT_W = 2 * BUS_W;
  localparam int ANY_BIT = BUS_W - 1;

  logic             a_run_q, b_run_q, b_casc_q;
  logic [CNT_W-1:0] a_cnt, b_cnt;
  logic             a_uf, b_uf, a_tick, b_tick;
  logic             flag_fall;
  logic [NSRC-1:0]  events, flags, mask;
  logic [BUS_W-1:0] icr_view, rd_mux, rd_q;
  logic             rd_clr;

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      a_run_q  <= 1'b0;
      b_run_q  <= 1'b0;
      b_casc_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADR_CTLA) a_run_q <= wr_data[RUN_BIT];
      if (addr == ADR_CTLB) begin
        b_run_q  <= wr_data[RUN_BIT];
        b_casc_q <= wr_data[CASC_BIT];
      end
    end
  end

  assign a_tick = a_run_q;
  assign b_tick = b_run_q & (b_casc_q ? a_uf : 1'b1);

  rt_down_counter #(.BYTE_W(BUS_W), .W(CNT_W)) u_cnt_a (
    .clk(clk), .rst(rst), .run(a_run_q), .tick(a_tick),
    .wr_lo(wr_en && addr == ADR_A_LO), .wr_hi(wr_en && addr == ADR_A_HI),
    .wr_byte(wr_data), .cnt(a_cnt), .uf(a_uf)
  );

  rt_down_counter #(.BYTE_W(BUS_W), .W(CNT_W)) u_cnt_b (
    .clk(clk), .rst(rst), .run(b_run_q), .tick(b_tick),
    .wr_lo(wr_en && addr == ADR_B_LO), .wr_hi(wr_en && addr == ADR_B_HI),
    .wr_byte(wr_data), .cnt(b_cnt), .uf(b_uf)
  );

  rt_flag_edge #(.STAGES(SYNC_STAGES)) u_flag (
    .clk(clk), .rst(rst), .pin_n(flag_n), .fall(flag_fall)
  );

  always_comb begin
    events           = '0;
    events[SRC_A]    = a_uf;
    events[SRC_B]    = b_uf;
    events[SRC_FLAG] = flag_fall;
  end

  assign rd_clr = rd_en && addr == ADR_ICR;

  rt_irq_ctl #(.NSRC(NSRC), .BUS_W(BUS_W)) u_irq (
    .clk(clk), .rst(rst), .events(events),
    .mask_wr(wr_en && addr == ADR_ICR), .mask_data(wr_data),
    .rd_clr(rd_clr), .flags(flags), .mask(mask), .irq_n(irq_n)
  );

  always_comb begin
    icr_view             = '0;
    icr_view[NSRC-1:0]   = flags;
    icr_view[ANY_BIT]    = |(flags & mask);
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_A_LO: rd_mux = a_cnt[BUS_W-1:0];
      ADR_A_HI: rd_mux = a_cnt[CNT_W-1:BUS_W];
      ADR_B_LO: rd_mux = b_cnt[BUS_W-1:0];
      ADR_B_HI: rd_mux = b_cnt[CNT_W-1:BUS_W];
      ADR_ICR:  rd_mux = icr_view;
      ADR_CTLA: rd_mux[RUN_BIT] = a_run_q;
      ADR_CTLB: begin
        rd_mux[RUN_BIT]  = b_run_q;
        rd_mux[CASC_BIT] = b_casc_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  // R6: in cascade mode counter B moves only on an A underflow
  p_b_cascade_r6: assert property (@(posedge clk) disable iff (rst)
    (b_run_q && b_casc_q && !a_uf) |=> $stable(b_cnt));

  // R4: a stopped counter A never underflows
  p_a_stopped_r4: assert property (@(posedge clk) disable iff (rst)
    !a_run_q |-> !a_uf);
endmodule

// File: tb/sim_rt_cascade_timer.sv
module sim_rt_cascade_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       flag_n = 1'b1;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rt_cascade_timer u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .flag_n(flag_n), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one edge per write: wr consumes the edge before its negedge return
  task automatic wr_fast(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    logic [15:0] v;
    chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
    chk("R1 rd_data", {8'd0, rd_data}, 16'd0);
    rd16(4'd0, v); chk("R1 counter A", v, 16'hFFFF);
    rd16(4'd2, v); chk("R1 counter B", v, 16'hFFFF);
    rd(4'd4, d);   chk("R1 icr", {8'd0, d}, 16'd0);
  endtask

  task automatic t_load;
    logic [15:0] v;
    wr(4'd0, 8'h34);
    rd16(4'd0, v); chk("R2 low write only to latch", v, 16'hFFFF);
    wr(4'd1, 8'h12);
    rd16(4'd0, v); chk("R3 stopped high write loads", v, 16'h1234);
  endtask

  task automatic t_run_hold;
    logic [15:0] v;
    wr(4'd0, 8'd10); wr(4'd1, 8'd0);
    wr_fast(4'd5, 8'h01);
    repeat (4) @(posedge clk);
    wr_fast(4'd5, 8'h00);
    rd16(4'd0, v); chk("R4 five counts", v, 16'd5);
    repeat (5) @(posedge clk);
    rd16(4'd0, v); chk("R4 hold when stopped", v, 16'd5);
  endtask

  task automatic t_hi_running;
    logic [15:0] v;
    wr(4'd0, 8'h40); wr(4'd1, 8'h00);
    wr_fast(4'd5, 8'h01);
    wr_fast(4'd1, 8'h07);
    wr_fast(4'd5, 8'h00);
    rd16(4'd0, v); chk("R3 running high write ignored by counter", v, 16'h003E);
  endtask

  task automatic t_cascade;
    logic [7:0] d;
    logic [15:0] v;
    rd(4'd4, d);
    wr(4'd0, 8'd3); wr(4'd1, 8'd0);
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd6, 8'h41);
    wr_fast(4'd5, 8'h01);
    repeat (21) @(posedge clk);
    wr_fast(4'd5, 8'h00);
    wr(4'd6, 8'h00);
    rd16(4'd0, v); chk("R5 A after 22 counts period 4", v, 16'd1);
    rd16(4'd2, v); chk("R6 B counts A underflows", v, 16'hFFFA);
    rd(4'd4, d);   chk("R5 flag bit0 no mask", {8'd0, d}, 16'h0001);
  endtask

  task automatic t_direct_b;
    logic [7:0] d;
    logic [15:0] v;
    wr(4'd2, 8'd2); wr(4'd3, 8'd0);
    wr_fast(4'd6, 8'h01);
    repeat (3) @(posedge clk);
    wr_fast(4'd6, 8'h00);
    rd16(4'd2, v); chk("R6 B clock mode reload", v, 16'd1);
    rd(4'd4, d);   chk("R6 flag bit1", {8'd0, d}, 16'h0002);
  endtask

  task automatic t_ms;
    logic [15:0] v;
    wr(4'd0, 8'hFC); wr(4'd1, 8'h03);
    wr(4'd2, 8'hFF); wr(4'd3, 8'hFF);
    wr(4'd6, 8'h41);
    wr_fast(4'd5, 8'h01);
    repeat (3062) @(posedge clk);
    wr_fast(4'd5, 8'h00);
    wr(4'd6, 8'h00);
    rd16(4'd0, v); chk("R7 A back at 0x03FC", v, 16'h03FC);
    rd16(4'd2, v); chk("R7 elapsed three periods", 16'hFFFF - v, 16'd3);
  endtask

  task automatic t_flag;
    logic [7:0] d;
    rd(4'd4, d);
    wr(4'd4, 8'h94);
    @(negedge clk); flag_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R8 not yet through synchroniser", {15'd0, irq_n}, 16'd1);
    @(posedge clk); @(negedge clk);
    chk("R11 irq low on enabled flag", {15'd0, irq_n}, 16'd0);
    repeat (3) @(posedge clk);
    flag_n = 1'b1;
    repeat (4) @(posedge clk);
    rd(4'd4, d);
    chk("R10 read shows pending and any bit", {8'd0, d}, 16'h0090);
    chk("R10 read releases irq", {15'd0, irq_n}, 16'd1);
    rd(4'd4, d);
    chk("R8 rising edge sets nothing", {8'd0, d}, 16'h0000);
    @(negedge clk); flag_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk); flag_n = 1'b1;
    chk("R11 irq low again", {15'd0, irq_n}, 16'd0);
    wr(4'd4, 8'h10);
    chk("R9 clear form masks irq", {15'd0, irq_n}, 16'd1);
    rd(4'd4, d);
    chk("R10 masked flag without any bit", {8'd0, d}, 16'h0010);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    wr(4'd4, 8'h90);
    rd(4'd4, d);
    @(negedge clk); flag_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); addr = 4'd4; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0;
    chk("R12 colliding read sees old state", {8'd0, rd_data}, 16'h0000);
    chk("R12 event kept, irq low", {15'd0, irq_n}, 16'd0);
    flag_n = 1'b1;
    rd(4'd4, d);
    chk("R12 second read reports flag", {8'd0, d}, 16'h0090);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset;
    t_load;
    t_run_hold;
    t_hi_running;
    t_cascade;
    t_direct_b;
    t_ms;
    t_flag;
    t_collide;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule